// File: doc/BRIEF.md
# Command-Selected Register Access Decoder

This block is the slave side of a small register bus in which the target register is picked by a command code written beforehand, not by address lines. An address-select input chooses the meaning of each write strobe: when it is high, the low byte of the 16-bit data bus is taken as a command code; when it is low, the bus carries data for the register that the last command selected.

Each command code maps to a kind (write data, read data, clear), a target register and a word count. Data-phase strobes walk through the selected register one 16-bit word at a time, lowest word first. Accesses past the count are absorbed. A clear command has no data phase and takes effect as soon as it is captured, and it raises a one-cycle execute pulse. The register file is internal. Register k (k = 0..NUM_REGS-1) is k+1 words long.

Top module: `cmdreg_access`

## Requirements
- R1: After reset, rdata_o and exec_o are 0, no command is selected, and every word of every register reads back as 0.
- R2: A write strobe with a0_i high is a command phase. Only wdata_i[7:0] forms the code, and wdata_i[15:8] has no effect on the outcome.
- R3: Code encoding, with k = code[3:0] and k below NUM_REGS (4). Codes 0x1k write register k with k+1 words. Codes 0x2k read register k with k+1 words. Codes 0x3k clear register k and have no data phase.
- R4: The n-th data-phase write (a0_i low) after a write command stores wdata_i into word n of the selected register. Word 0 is the least significant word and is transferred first.
- R5: The n-th data-phase read after a read command loads word n of the selected register into rdata_o on the clock edge that samples the strobe. The value holds until the next data-phase read.
- R6: A clear command zeroes its register on the edge that captures the command. exec_o is high for exactly the cycle after that edge, and only for valid clear commands.
- R7: Data-phase writes beyond the command's word count change no register. Data-phase reads beyond the count return 0.
- R8: Any command phase aborts a data phase in progress and restarts the word index at 0.
- R9: A code outside the encoding of R3 raises no exec_o. Later data writes change no register, and later data reads return 0.
- R10: Data writes under a read or clear command change nothing. Data reads under a write or clear command return 0.
- R11: A read strobe is ignored, and rdata_o holds, when a0_i is high or when wr_stb_i is high in the same cycle. In that second case the write is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a0_i | input | 1 | High: command phase; low: data phase |
| wr_stb_i | input | 1 | Write strobe, one access per cycle it is high |
| rd_stb_i | input | 1 | Read strobe, one access per cycle it is high |
| wdata_i | input | 16 | Write data or command code (low byte) |
| rdata_o | output | 16 | Read data word |
| exec_o | output | 1 | One-cycle pulse when a clear command executes |

## Verification
Both visible results are registered once. rdata_o and exec_o change on the rising edge that samples the strobe. The bench drives each strobe for one cycle from a falling edge and compares on the next falling edge, half a period after the result appears. Register contents and the clear effect are not visible at once. They are observed through a later read command and its data reads, each checked against a bench model of the register words. Random command, write and read mixes follow directed cases for overrun, abort, unknown codes and direction mismatch.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2,
    K_CLEAR = 2'd3
  } cmd_kind_e;

  localparam logic [3:0] GRP_WRITE = 4'h1;
  localparam logic [3:0] GRP_READ  = 4'h2;
  localparam logic [3:0] GRP_CLEAR = 4'h3;
endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic [7:0]       code_i,
  output cmd_kind_e        kind_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] count_o
);
  logic [3:0] grp;
  logic [3:0] low;
  logic       in_range;

  always_comb begin
    grp      = code_i[7:4];
    low      = code_i[3:0];
    in_range = (32'(low) < NUM_REGS);
    kind_o   = K_NONE;
    sel_o    = SEL_W'(low);
    count_o  = '0;
    if (in_range) begin
      case (grp)
        GRP_WRITE: begin
          kind_o  = K_WRITE;
          count_o = CNT_W'(low) + CNT_W'(1);
        end
        GRP_READ: begin
          kind_o  = K_READ;
          count_o = CNT_W'(low) + CNT_W'(1);
        end
        GRP_CLEAR: begin
          kind_o  = K_CLEAR;
          count_o = '0;
        end
        default: kind_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmdreg_seq.sv
module cmdreg_seq
  import cmdreg_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  cmd_kind_e        kind_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  output cmd_kind_e        kind_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [SEL_W-1:0] widx_o,
  output logic             in_win_o
);
  cmd_kind_e        kind_q, kind_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             en;

  always_comb begin
    kind_d = kind_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    en     = load_i | step_i;
    if (load_i) begin
      kind_d = kind_i;
      sel_d  = sel_i;
      cnt_d  = cnt_i;
      idx_d  = '0;
    end else if (step_i && (idx_q < cnt_q)) begin
      idx_d = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      sel_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (en) begin
      kind_q <= kind_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  assign kind_o   = kind_q;
  assign sel_o    = sel_q;
  assign widx_o   = idx_q[SEL_W-1:0];
  assign in_win_o = (idx_q < cnt_q);

  // R8: a command phase restarts the word index
  a_r8_index_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_q == '0));
  // R7: the index never runs past the word count
  a_r7_index_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= cnt_q);
endmodule

// File: rtl/cmdreg_regs.sv
module cmdreg_regs #(
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              clr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SEL_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  rsel_i,
  input  logic [SEL_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rword_o
);
  logic [NUM_REGS-1:0][NUM_REGS-1:0][DATA_W-1:0] store;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
      if (w <= k) begin : g_live
        logic              hit;
        logic [DATA_W-1:0] word_d;
        logic [DATA_W-1:0] word_q;

        always_comb begin
          hit    = (sel_i == SEL_W'(k)) &&
                   (clr_i || (we_i && (widx_i == SEL_W'(w))));
          word_d = clr_i ? '0 : wdata_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            word_q <= '0;
          end else if (hit) begin
            word_q <= word_d;
          end
        end

        assign store[k][w] = word_q;
      end else begin : g_pad
        assign store[k][w] = '0;
      end
    end
  end

  assign rword_o = store[rsel_i][ridx_i];

  // R10 / R9: contents change only under a write or clear enable
  a_r10_store_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i || clr_i) |=> $stable(store));
endmodule

// File: rtl/cmdreg_access.sv
module cmdreg_access
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a0_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              exec_o
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = $clog2(NUM_REGS + 1);

  logic rst_s0, rst_s1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  logic rst_n;
  assign rst_n = rst_s1;

  logic cmd_stb, dwr, drd;
  assign cmd_stb = wr_stb_i & a0_i;
  assign dwr     = wr_stb_i & ~a0_i;
  assign drd     = rd_stb_i & ~a0_i & ~wr_stb_i;

  cmd_kind_e        dec_kind;
  logic [SEL_W-1:0] dec_sel;
  logic [CNT_W-1:0] dec_cnt;

  cmdreg_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_decode (
    .code_i (wdata_i[7:0]),
    .kind_o (dec_kind),
    .sel_o  (dec_sel),
    .count_o(dec_cnt)
  );

  cmd_kind_e        cur_kind;
  logic [SEL_W-1:0] cur_sel, widx;
  logic             in_win, we, rd_ok, clr, step;

  always_comb begin
    we    = dwr & (cur_kind == K_WRITE) & in_win;
    rd_ok = drd & (cur_kind == K_READ) & in_win;
    clr   = cmd_stb & (dec_kind == K_CLEAR);
    step  = we | rd_ok;
  end

  cmdreg_seq #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (cmd_stb),
    .kind_i  (dec_kind),
    .sel_i   (dec_sel),
    .cnt_i   (dec_cnt),
    .step_i  (step),
    .kind_o  (cur_kind),
    .sel_o   (cur_sel),
    .widx_o  (widx),
    .in_win_o(in_win)
  );

  logic [SEL_W-1:0]  wsel;
  logic [DATA_W-1:0] rword;
  assign wsel = clr ? dec_sel : cur_sel;

  cmdreg_regs #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (we),
    .clr_i  (clr),
    .sel_i  (wsel),
    .widx_i (widx),
    .wdata_i(wdata_i),
    .rsel_i (cur_sel),
    .ridx_i (widx),
    .rword_o(rword)
  );

  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              exec_d, exec_q;

  always_comb begin
    rdata_d = rd_ok ? rword : '0;
    exec_d  = clr;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      exec_q  <= 1'b0;
    end else begin
      if (drd) rdata_q <= rdata_d;
      exec_q <= exec_d;
    end
  end

  assign rdata_o = rdata_q;
  assign exec_o  = exec_q;

  // R6: a pulse only follows a command-phase strobe
  a_r6_exec_cause: assert property (@(posedge clk_i) disable iff (!rst_n)
    exec_o |-> $past(wr_stb_i && a0_i));
  // R9: unknown codes never execute
  a_r9_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_stb && (dec_kind == K_NONE)) |=> !exec_o);
  // R7: a read outside the window returns zero
  a_r7_zero_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    (drd && !rd_ok) |=> (rdata_o == '0));
  // R11: ignored read strobes leave rdata untouched
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_stb_i && (a0_i || wr_stb_i)) |=> $stable(rdata_o));
endmodule

// File: tb/test_cmdreg_access.sv
module test_cmdreg_access;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a0, wr, rd;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        exec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmdreg_access i_cmdreg_access (
    .clk_i(clk), .rst_ni(rst_n), .a0_i(a0), .wr_stb_i(wr), .rd_stb_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .exec_o(exec)
  );

  // bench model
  logic [15:0] m_reg [4][4];
  int          m_kind;   // 0 none, 1 write, 2 read, 3 clear
  int          m_sel, m_cnt, m_idx;
  logic [15:0] m_rdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int code_kind(input logic [7:0] c);
    if (c[3:0] >= 4) return 0;
    case (c[7:4])
      4'h1: return 1;
      4'h2: return 2;
      4'h3: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic pulse(input bit a, input bit w, input bit r, input logic [15:0] d);
    @(negedge clk);
    a0 = a; wr = w; rd = r; wdata = d;
    @(negedge clk);
    a0 = 1'b0; wr = 1'b0; rd = 1'b0; wdata = 16'h0;
  endtask

  task automatic do_cmd(input logic [7:0] code, input logic [7:0] upper, input string tag);
    int k;
    k = code_kind(code);
    pulse(1'b1, 1'b1, 1'b0, {upper, code});
    m_kind = k; m_sel = int'(code[3:0]); m_idx = 0;
    m_cnt = (k == 1 || k == 2) ? m_sel + 1 : 0;
    if (k == 3) for (int w = 0; w < 4; w++) m_reg[m_sel][w] = 16'h0;
    check(exec == (k == 3), tag, int'(exec), int'(k == 3));
  endtask

  task automatic model_write(input logic [15:0] d);
    if (m_kind == 1 && m_idx < m_cnt) begin
      m_reg[m_sel][m_idx] = d;
      m_idx++;
    end
  endtask

  task automatic do_wr(input logic [15:0] d);
    pulse(1'b0, 1'b1, 1'b0, d);
    model_write(d);
  endtask

  task automatic do_rd(input string tag);
    logic [15:0] e;
    pulse(1'b0, 1'b0, 1'b1, 16'h0);
    if (m_kind == 2 && m_idx < m_cnt) begin
      e = m_reg[m_sel][m_idx];
      m_idx++;
    end else begin
      e = 16'h0;
    end
    m_rdata = e;
    check(rdata == e, tag, int'(rdata), int'(e));
  endtask

  task automatic do_rd_a0(input string tag);
    pulse(1'b1, 1'b0, 1'b1, 16'h0);
    check(rdata == m_rdata, tag, int'(rdata), int'(m_rdata));
  endtask

  task automatic do_rd_wr(input logic [15:0] d, input string tag);
    pulse(1'b0, 1'b1, 1'b1, d);
    model_write(d);
    check(rdata == m_rdata, tag, int'(rdata), int'(m_rdata));
  endtask

  task automatic read_back(input int k, input string tag);
    do_cmd(8'h20 + 8'(k), 8'h00, tag);
    for (int w = 0; w <= k; w++) do_rd(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    int op;
    a0 = 1'b0; wr = 1'b0; rd = 1'b0; wdata = 16'h0;
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) for (int w = 0; w < 4; w++) m_reg[k][w] = 16'h0;
    m_kind = 0; m_sel = 0; m_cnt = 0; m_idx = 0; m_rdata = 16'h0;
    repeat (3) @(negedge clk);
    check(rdata == 16'h0, "R1 rdata", int'(rdata), 0);
    check(exec == 1'b0, "R1 exec", int'(exec), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_rd("R1 no command");
    for (int k = 0; k < 4; k++) read_back(k, "R1 regs zero");

    // R2/R4: upper byte of command ignored, words in LSW-first order
    do_cmd(8'h12, 8'hA5, "R2 write cmd");
    do_wr(16'h1111); do_wr(16'h2222); do_wr(16'h3333);
    do_wr(16'hDEAD);                         // R7 extra write
    do_cmd(8'h22, 8'h7E, "R3 read cmd");
    do_rd("R4 word0"); do_rd("R5 word1"); do_rd("R5 word2");
    do_rd("R7 over read");
    read_back(3, "R7 neighbour untouched");

    // R6: clear executes immediately
    do_cmd(8'h32, 8'hFF, "R6 clear exec");
    do_rd("R10 read under clear");
    read_back(2, "R6 cleared");

    // R8: abort restarts index
    do_cmd(8'h13, 8'h00, "R8 cmd");
    do_wr(16'hAAAA); do_wr(16'hBBBB);
    do_cmd(8'h13, 8'h00, "R8 recmd");
    do_wr(16'hCCCC);
    read_back(3, "R8 restart");
    do_cmd(8'h23, 8'h00, "R8 read cmd");
    do_rd("R8 partial");
    do_cmd(8'h23, 8'h00, "R8 read recmd");
    do_rd("R8 reread word0");

    // R9: unknown codes
    do_cmd(8'h14, 8'h00, "R9 out of range");
    do_wr(16'h5555); do_rd("R9 read");
    do_cmd(8'h55, 8'h00, "R9 bad group");
    do_wr(16'h6666); do_rd("R9 read2");
    do_cmd(8'h00, 8'h31, "R2 upper is not code");
    read_back(0, "R9 reg0"); read_back(3, "R9 reg3");

    // R10: direction mismatch
    do_cmd(8'h21, 8'h00, "R10 read cmd");
    do_wr(16'h7777);
    do_rd("R10 unchanged"); do_rd("R10 unchanged");
    do_cmd(8'h11, 8'h00, "R10 write cmd");
    do_rd("R10 read under write");
    do_wr(16'h8888);
    read_back(1, "R10 write after read");

    // R11: ignored read strobes
    do_cmd(8'h23, 8'h00, "R11 cmd");
    do_rd("R11 load");
    do_rd_a0("R11 a0 high");
    do_cmd(8'h10, 8'h00, "R11 wcmd");
    do_rd_wr(16'h9999, "R11 with write");
    read_back(0, "R11 write done");

    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      op = int'($urandom_range(99));
      if (op < 25) begin
        c = {4'($urandom_range(4)), 4'($urandom_range(5))};
        do_cmd(c, 8'($urandom), "R3 random cmd");
      end else if (op < 60) begin
        do_wr(16'($urandom));
      end else if (op < 94) begin
        do_rd("R5 random read");
      end else if (op < 97) begin
        do_rd_a0("R11 random");
      end else begin
        do_rd_wr(16'($urandom), "R11 random both");
      end
    end
    for (int k = 0; k < 4; k++) read_back(k, "R4 final contents");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule